// File: doc/BRIEF.md
# Pre-Trigger Capture Buffer

This block is a 32-entry sample store that keeps the history leading up to an event. Before any trigger it runs as a circular stream: every valid sample is written, and once the store is full the oldest entry gives way to the newest. When a trigger is seen on a sample, the block stops dropping old samples and accepts new ones only until it is full. It then freezes, so the contents end at a fixed offset after the trigger: thirty samples from before the event, the trigger sample, and one sample after it.

The host reads entries out oldest-first through a pop strobe. Reading the buffer out does not rearm it. To take a fresh capture, the host selects bypass mode, which empties the store and clears both flags, and then selects stream-to-FIFO mode again. A one-bit mode input selects the mode: 0 means bypass and 1 means stream-to-FIFO.

The controller has four states. BYPASS means the store is held empty. STREAM means circular capture. POST means the trigger has been seen and the store is filling to its limit. FROZEN means collection has stopped. The transitions are: arm (BYPASS to STREAM when the mode is 1), switch (STREAM to POST on a trigger sample), freeze (POST to FROZEN), fallback (POST to STREAM when an early trigger has gone away by the time the store fills), and disarm (any state to BYPASS when the mode is 0).

Top module: `ptb_capture`

## Requirements
- R1: After reset the block is in bypass. `level_o` is 0, `full_o` is 0, `switched_o` is 0 and `rd_data_o` is 0.
- R2: A mode value of 0 at a clock edge empties the store. `level_o` becomes 0 and `full_o` and `switched_o` become 0. While in bypass, samples and pops have no effect on `level_o`.
- R3: In stream capture each valid sample is stored. With 32 entries held and no pop in the same cycle, a new sample discards the oldest entry and `level_o` stays at 32.
- R4: A trigger sample is a valid sample that arrives in stream capture while `trig_i` is 1. A valid sample that follows a cycle in which `trig_i` was 1 without a valid sample is also a trigger sample, provided no valid sample came in between. `switched_o` is 1 from the edge after the trigger sample until the next bypass.
- R5: Suppose a trigger sample arrives while the store already holds 32 entries. The store then takes exactly one further sample and freezes. `full_o` is 1 and the contents are the 30 samples before the trigger, the trigger sample and the one sample after it.
- R6: Suppose the trigger sample arrives before the store is full. Samples are appended with no discard until 32 entries are held. If `trig_i` is 1 on the sample that fills the store, the block freezes. Otherwise it returns to stream capture with `full_o` at 0 and `switched_o` still 1.
- R7: While frozen, samples are ignored. Popping entries, even down to `level_o` = 0, leaves `full_o` at 1 and does not restart collection.
- R8: Capture restarts only after a bypass followed by a mode value of 1. The edge after the mode becomes 1 only arms the block, and the sample presented in that cycle is ignored.
- R9: A pop with entries present removes the oldest entry. The entry appears on `rd_data_o` after the next edge, and `level_o` drops by one.
- R10: A pop with the store empty leaves `rd_data_o` and `level_o` unchanged.
- R11: A pop and a stored sample in the same cycle with 32 entries held return the oldest entry and discard nothing else. `level_o` stays at 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 selects bypass, 1 selects stream-to-FIFO |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | DW | Sample value |
| trig_i | input | 1 | Trigger level |
| pop_i | input | 1 | Read strobe, removes the oldest entry |
| rd_data_o | output | DW | Last entry popped |
| full_o | output | 1 | Capture frozen (overrun/full) |
| switched_o | output | 1 | Trigger has switched stream capture to FIFO filling |
| level_o | output | $clog2(DEPTH+1) | Number of entries held |

## Verification
A pop and a sample write can land in the same cycle. When the store is full, that decides whether the oldest entry is read out or silently discarded. The same collision also decides whether a post-trigger sample completes the fill or is the single sample allowed after the trigger. The bench sets this up on purpose with a full stream buffer, then keeps it up through long runs of random pops mixed with random samples and triggers. A behavioural queue model predicts the level, the flags and every popped value, and these are compared on each cycle.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_STREAM = 2'd1,
        ST_POST   = 2'd2,
        ST_FROZEN = 2'd3
    } ptb_state_e;
endpackage

// File: rtl/ptb_ring.sv
module ptb_ring #(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count;
    logic          do_pop, do_drop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign do_pop  = pop && (count != '0);
    assign do_drop = push && (count == LW'(DEPTH)) && !do_pop;
    assign level   = count;

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            rdata  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop || do_drop) begin
                rd_ptr <= bump(rd_ptr);
            end
            if (do_pop) begin
                rdata <= mem[rd_ptr];
            end
            if (push && !do_pop && !do_drop) begin
                count <= count + LW'(1);
            end else if (do_pop && !push) begin
                count <= count - LW'(1);
            end
        end
    end

    // R10: popping an empty store changes neither level nor read data
    a_r10_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !clr && count == '0) |=> ($stable(rdata) && count == '0));

    // R11: push plus pop while full keeps the level at the limit
    a_r11_pushpop_full: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !clr && count == LW'(DEPTH)) |=> (count == LW'(DEPTH)));

    // R3: the level never exceeds the depth
    a_r3_level_cap: assert property (@(posedge clk) disable iff (rst)
        (count <= LW'(DEPTH)));
endmodule

// File: rtl/ptb_trig.sv
module ptb_trig (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic valid,
    input  logic trig,
    output logic hit
);
    logic pend_q;

    assign hit = trig || pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= armed && !valid && (trig || pend_q);
        end
    end

    // R4: a held pulse is consumed by the next sample
    a_r4_pend_consumed: assert property (@(posedge clk) disable iff (rst)
        valid |=> !pend_q);
endmodule

// File: rtl/ptb_ctrl.sv
module ptb_ctrl
    import ptb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode,
    input  logic          valid,
    input  logic          trig_hit,
    input  logic          trig_lvl,
    input  logic          pop,
    input  logic [LW-1:0] level,
    output ptb_state_e    state,
    output logic          push,
    output logic          clr,
    output logic          switched
);
    ptb_state_e    state_d;
    logic          sw_d;
    logic [LW-1:0] eff;

    assign eff = level - ((pop && level != '0) ? LW'(1) : LW'(0));

    always_comb begin
        state_d = state;
        sw_d    = switched;
        if (!mode) begin
            state_d = ST_BYPASS;
            sw_d    = 1'b0;
        end else begin
            unique case (state)
                ST_BYPASS: state_d = ST_STREAM;
                ST_STREAM: begin
                    if (valid && trig_hit) begin
                        state_d = ST_POST;
                        sw_d    = 1'b1;
                    end
                end
                ST_POST: begin
                    if (valid) begin
                        if (eff == LW'(DEPTH)) begin
                            state_d = ST_FROZEN;
                        end else if (eff == LW'(DEPTH - 1)) begin
                            state_d = trig_lvl ? ST_FROZEN : ST_STREAM;
                        end
                    end
                end
                ST_FROZEN: state_d = ST_FROZEN;
                default:   state_d = ST_BYPASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_BYPASS;
            switched <= 1'b0;
        end else begin
            state    <= state_d;
            switched <= sw_d;
        end
    end

    always_comb begin
        clr  = !mode || (state == ST_BYPASS);
        push = mode && valid && ((state == ST_STREAM) || (state == ST_POST));
    end

    // R2: a bypass request always lands in bypass
    a_r2_disarm: assert property (@(posedge clk) disable iff (rst)
        !mode |=> (state == ST_BYPASS && !switched));

    // R7: frozen holds until bypass
    a_r7_frozen_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FROZEN && mode) |=> (state == ST_FROZEN));

    // R5: the one sample after a full trigger freezes the store
    a_r5_one_after: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POST && mode && valid && eff == LW'(DEPTH)) |=> (state == ST_FROZEN));

    // R4: a trigger sample in stream capture sets the switched flag
    a_r4_switch: assert property (@(posedge clk) disable iff (rst)
        (state == ST_STREAM && mode && valid && trig_hit) |=> (switched && state == ST_POST));
endmodule

// File: rtl/ptb_capture.sv
module ptb_capture
    import ptb_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 32,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_i,
    input  logic          smp_valid_i,
    input  logic [DW-1:0] smp_data_i,
    input  logic          trig_i,
    input  logic          pop_i,
    output logic [DW-1:0] rd_data_o,
    output logic          full_o,
    output logic          switched_o,
    output logic [LW-1:0] level_o
);
    ptb_state_e    state;
    logic          push, clr, hit, ring_pop;
    logic [LW-1:0] level;

    assign ring_pop = pop_i && !clr;

    ptb_trig u_trig (
        .clk   (clk),
        .rst   (rst),
        .armed (mode_i && state == ST_STREAM),
        .valid (smp_valid_i),
        .trig  (trig_i),
        .hit   (hit)
    );

    ptb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode_i),
        .valid    (smp_valid_i),
        .trig_hit (hit),
        .trig_lvl (trig_i),
        .pop      (ring_pop),
        .level    (level),
        .state    (state),
        .push     (push),
        .clr      (clr),
        .switched (switched_o)
    );

    ptb_ring #(.DW(DW), .DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .push  (push),
        .pop   (ring_pop),
        .wdata (smp_data_i),
        .rdata (rd_data_o),
        .level (level)
    );

    assign level_o = level;
    assign full_o  = (state == ST_FROZEN);

    // R2: bypass always means an empty store
    a_r2_bypass_empty: assert property (@(posedge clk) disable iff (rst)
        (state == ST_BYPASS) |-> (level == '0));

    // R5: freezing happens only with a full store
    a_r5_full_level: assert property (@(posedge clk) disable iff (rst)
        $rose(full_o) |-> (level == LW'(DEPTH)));
endmodule

// File: tb/ptb_capture_tb.sv
`timescale 1ns/1ps
module ptb_capture_tb;
    localparam int DW = 16;
    localparam int DEPTH = 32;
    localparam int LW = $clog2(DEPTH + 1);

    logic clk = 0, rst = 1, mode = 0, v = 0, t = 0, p = 0;
    logic [DW-1:0] d = '0;
    logic [DW-1:0] rd;
    logic full, sw;
    logic [LW-1:0] lvl;

    int total = 0, bad = 0;
    bit started = 0, finished = 0;

    logic [DW-1:0] q[$];
    int m_st = 0;
    bit m_pend = 0, m_sw = 0;
    logic [DW-1:0] m_rd = '0;

    always #2 clk = ~clk;

    ptb_capture #(.DW(DW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .mode_i(mode), .smp_valid_i(v), .smp_data_i(d),
        .trig_i(t), .pop_i(p), .rd_data_o(rd), .full_o(full),
        .switched_o(sw), .level_o(lvl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_st = 0; m_pend = 0; m_sw = 0; m_rd = '0;
        end else if (!mode) begin
            q.delete(); m_st = 0; m_pend = 0; m_sw = 0;
        end else if (m_st == 0) begin
            m_st = 1;
        end else begin
            if (p && q.size() > 0) m_rd = q.pop_front();
            if (m_st == 1) begin
                if (v) begin
                    if (q.size() == DEPTH) void'(q.pop_front());
                    q.push_back(d);
                    if (t || m_pend) begin m_st = 2; m_sw = 1; end
                    m_pend = 0;
                end else if (t) m_pend = 1;
            end else if (m_st == 2) begin
                m_pend = 0;
                if (v) begin
                    if (q.size() == DEPTH) begin
                        void'(q.pop_front()); q.push_back(d); m_st = 3;
                    end else begin
                        q.push_back(d);
                        if (q.size() == DEPTH) m_st = t ? 3 : 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            chk("R3 level", int'(lvl), q.size());
            chk("R5 full", int'(full), (m_st == 3) ? 1 : 0);
            chk("R4 switched", int'(sw), int'(m_sw));
            chk("R9 rd_data", int'(rd), int'(m_rd));
        end
    end

    task automatic drive(input logic m_i, input logic v_i, input int d_i,
                         input logic t_i, input logic p_i);
        @(negedge clk); #1;
        mode = m_i; v = v_i; d = DW'(d_i); t = t_i; p = p_i;
    endtask

    task automatic idle(input logic m_i);
        drive(m_i, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1 rst = 0;
        started = 1;
        idle(0);
        chk("R1 level", int'(lvl), 0); chk("R1 full", int'(full), 0);
        chk("R1 switched", int'(sw), 0); chk("R1 rd", int'(rd), 0);
        drive(0, 1, 7, 0, 0); idle(0);
        chk("R2 bypass ignores sample", int'(lvl), 0);

        // prefilled trigger via held pulse
        drive(1, 1, 99, 0, 0);
        for (int i = 1; i <= 34; i++) drive(1, 1, i, 0, 0);
        drive(1, 0, 0, 1, 0);
        drive(1, 1, 35, 0, 0);
        drive(1, 1, 36, 0, 0);
        idle(1);
        chk("R8 arm sample ignored / R5 level", int'(lvl), DEPTH);
        chk("R5 full", int'(full), 1); chk("R4 switched", int'(sw), 1);
        drive(1, 1, 37, 0, 0); idle(1);
        chk("R7 frozen ignores sample", int'(lvl), DEPTH);
        drive(1, 0, 0, 0, 1); idle(1);
        chk("R5 oldest kept", int'(rd), 5);
        for (int i = 0; i < DEPTH - 1; i++) drive(1, 0, 0, 0, 1);
        idle(1);
        chk("R5 one after trigger", int'(rd), 36);
        chk("R9 drained", int'(lvl), 0);
        chk("R7 full after drain", int'(full), 1);
        drive(1, 0, 0, 0, 1); idle(1);
        chk("R10 rd held", int'(rd), 36); chk("R10 level", int'(lvl), 0);
        drive(1, 1, 38, 0, 0); idle(1);
        chk("R7 no rearm by reading", int'(lvl), 0);
        idle(0); idle(0);
        chk("R2 full cleared", int'(full), 0); chk("R2 switched cleared", int'(sw), 0);

        // early trigger, held high
        idle(1);
        for (int i = 0; i <= 40; i++) drive(1, 1, 100 + i, (i >= 2), 0);
        idle(1);
        chk("R6 early held freezes", int'(full), 1);
        chk("R6 level", int'(lvl), DEPTH);
        drive(1, 0, 0, 0, 1); idle(1);
        chk("R6 first entry", int'(rd), 100);
        idle(0);

        // early trigger, released before fill
        idle(1);
        for (int i = 0; i <= 39; i++) drive(1, 1, 200 + i, (i == 1), 0);
        idle(1);
        chk("R6 fallback not full", int'(full), 0);
        chk("R6 switched kept", int'(sw), 1);
        chk("R3 level saturates", int'(lvl), DEPTH);
        drive(1, 0, 0, 0, 1); idle(1);
        chk("R3 oldest dropped", int'(rd), 208);
        drive(1, 1, 240, 0, 0);
        drive(1, 1, 241, 0, 1); idle(1);
        chk("R11 pop returns oldest", int'(rd), 209);
        chk("R11 level kept", int'(lvl), DEPTH);
        idle(0);

        // random mix, model compared every cycle
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 999);
            drive((r < 8) ? 1'b0 : 1'b1, $urandom_range(0, 2) != 0,
                  int'($urandom_range(0, 65535)), $urandom_range(0, 40) == 0,
                  $urandom_range(0, 3) == 0);
        end
        idle(1); idle(1);
        finish_run();
    end
endmodule